// File: doc/BRIEF.md
# Configurable Inverting Logic Unit

This block is a purely combinational bitwise logic unit. It takes two operands of equal width, optionally complements each of them on entry, applies one of four bitwise Boolean functions to the conditioned pair, and optionally complements the chosen result before driving it out. Each of the three inversion points has its own control bit. Combining them with the four base functions gives a wide family of two-input Boolean operations, such as NAND, NOR and the implications, without any extra function logic.

It is meant to sit inside a datapath as a single level of logic between registers. The operand width is a parameter with a default of 4 bits. The block has no clock, no state and no flags.

Top module: `inv_logic_unit`

## Requirements
- R1: When `inv_a` is 0 the A operand is used unchanged; when it is 1 every bit of `a_in` is complemented before the function stage.
- R2: When `inv_b` is 0 the B operand is used unchanged; when it is 1 every bit of `b_in` is complemented before the function stage.
- R3: `fsel` = 2'b00 selects the bitwise AND of the conditioned operands.
- R4: `fsel` = 2'b01 selects the bitwise OR of the conditioned operands.
- R5: `fsel` = 2'b10 selects the bitwise XOR of the conditioned operands.
- R6: `fsel` = 2'b11 selects the bitwise XNOR of the conditioned operands.
- R7: When `inv_y` is 1, `y_out` is the bitwise complement of the selected function result; when it is 0, `y_out` equals that result.
- R8: The block has no storage: `y_out` follows any input change without any clock edge.
- R9: With `inv_a` = `inv_b` = `inv_y` = 1 and `fsel` = 2'b01, `y_out` equals `a_in` AND `b_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | First operand |
| b_in | input | W | Second operand |
| inv_a | input | 1 | Complement the first operand |
| inv_b | input | 1 | Complement the second operand |
| inv_y | input | 1 | Complement the selected result |
| fsel | input | 2 | Function select: 0 AND, 1 OR, 2 XOR, 3 XNOR |
| y_out | output | W | Result |

## Verification
The bench builds the unit at its default width of 4 bits, which makes the full input space only 8192 points. Every combination of both operands, all three inversion controls and all four select codes is applied, and each output is compared with a value the bench derives arithmetically from the operand integers. Sampling shortly after each change, with no clock edge in between, covers the absence of storage.

// File: rtl/inv_logic_unit.sv
module inv_logic_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic         inv_y,
  input  logic [1:0]   fsel,
  output logic [W-1:0] y_out
);

  logic [W-1:0] ca, cb, res, yv;

  always_comb begin
    ca = inv_a ? ~a_in : a_in;
    cb = inv_b ? ~b_in : b_in;
    case (fsel)
      2'd0:    res = ca & cb;
      2'd1:    res = ca | cb;
      2'd2:    res = ca ^ cb;
      default: res = ~(ca ^ cb);
    endcase
    yv = inv_y ? ~res : res;

    if (!$isunknown({a_in, b_in, inv_a, inv_b, inv_y, fsel})) begin
      assert_opa_cond_R1: assert ((ca ^ a_in) == {W{inv_a}});
      assert_opb_cond_R2: assert ((cb ^ b_in) == {W{inv_b}});
      if (fsel == 2'd0) begin
        assert_and_fn_R3: assert (~res == (~ca | ~cb));
      end
      if (fsel == 2'd1) begin
        assert_or_fn_R4: assert (~res == (~ca & ~cb));
      end
      if (fsel == 2'd2) begin
        assert_xor_fn_R5: assert (res == ((ca | cb) & ~(ca & cb)));
      end
      if (fsel == 2'd3) begin
        assert_xnor_fn_R6: assert (res == ((ca & cb) | (~ca & ~cb)));
      end
      assert_out_inv_R7: assert ((yv ^ res) == {W{inv_y}});
      if (inv_a && inv_b && inv_y && fsel == 2'd1) begin
        assert_demorgan_R9: assert (yv == (a_in & b_in));
      end
    end
  end

  assign y_out = yv;

endmodule

// File: tb/inv_logic_unit_tb_top.sv
`timescale 1ns/1ps
module inv_logic_unit_tb_top;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic clk = 1'b0;
  logic [W-1:0] a, b;
  logic ia, ib, iy;
  logic [1:0] fs;
  logic [W-1:0] y;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  inv_logic_unit #(.W(W)) dut_i (
    .a_in(a), .b_in(b), .inv_a(ia), .inv_b(ib), .inv_y(iy),
    .fsel(fs), .y_out(y)
  );

  function automatic int model(int av, int bv, int xa, int xb, int xy, int f);
    int ca, cb, r;
    ca = xa ? (M - av) : av;
    cb = xb ? (M - bv) : bv;
    r = 0;
    for (int k = 0; k < W; k++) begin
      int ba, bb, br;
      ba = (ca >> k) % 2;
      bb = (cb >> k) % 2;
      case (f)
        0: br = ba * bb;
        1: br = (ba + bb > 0) ? 1 : 0;
        2: br = (ba + bb) % 2;
        default: br = 1 - ((ba + bb) % 2);
      endcase
      r = r + (br << k);
    end
    return xy ? (M - r) : r;
  endfunction

  task automatic check(string tag, int exp);
    checks++;
    if (int'(y) != exp) begin
      errors++;
      $display("FAIL %s: a=%0d b=%0d inv=%0d%0d%0d fsel=%0d actual=%0d expected=%0d",
               tag, a, b, ia, ib, iy, fs, y, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    a = '0; b = '0; ia = 0; ib = 0; iy = 0; fs = 2'd0;
    #0.5;
    check("R3 idle", 0);
    for (int f = 0; f < 4; f++)
      for (int xy = 0; xy < 2; xy++)
        for (int xa = 0; xa < 2; xa++)
          for (int xb = 0; xb < 2; xb++)
            for (int av = 0; av <= M; av++)
              for (int bv = 0; bv <= M; bv++) begin
                string tag;
                a = W'(av); b = W'(bv); ia = 1'(xa); ib = 1'(xb);
                iy = 1'(xy); fs = 2'(f);
                #0.5;
                case (f)
                  0: tag = "R3";
                  1: tag = "R4";
                  2: tag = "R5";
                  default: tag = "R6";
                endcase
                if (xa != 0) tag = {tag, " R1"};
                if (xb != 0) tag = {tag, " R2"};
                if (xy != 0) tag = {tag, " R7"};
                check(tag, model(av, bv, xa, xb, xy, f));
                if (xa == 1 && xb == 1 && xy == 1 && f == 1)
                  check("R9 demorgan", av & bv);
              end
    @(negedge clk);
    a = 4'hA; b = 4'h6; ia = 0; ib = 0; iy = 0; fs = 2'd2;
    #0.2;
    check("R8 settle xor", 12);
    fs = 2'd0;
    #0.2;
    check("R8 settle and", 2);
    iy = 1;
    #0.2;
    check("R8 settle nand", 13);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule